// File: doc/BRIEF.md
# Predicate-Prefix Conditional Execution Sequencer

This block sits beside an in-order issue stage and turns a single prefix instruction into execute-enables for the instructions that follow it. When the prefix is decoded, the issue stage hands the block a 4-bit base condition code and a slot mask. The block then opens a window of one to `NUM_SLOTS` slots. Each slot uses either the base condition or its inverse. For every later instruction that issues inside the window, the block evaluates that slot's condition against the current flags and drives `exec_en`. The prefix itself changes nothing but the window.

The block holds the negative/zero/carry/overflow flag register. An instruction that sets flags updates it only when its `exec_en` is high. The next slot is evaluated against the updated flags. Outside a window every instruction executes. A prefix that arrives while a window is open raises a one-cycle sequence error. Exception entry closes the window.

The control is a two-state machine, with states `ST_IDLE` and `ST_WIN`, and these transitions:
- `OPEN` (`ST_IDLE` to `ST_WIN`): a prefix arrives with a non-zero mask.
- `STEP` (`ST_WIN` to `ST_WIN`): an instruction issues and slots remain.
- `LAST` (`ST_WIN` to `ST_IDLE`): the final slot issues.
- `FLUSH` (`ST_WIN` to `ST_IDLE`): an exception is entered.
- `ILLEGAL` (`ST_WIN` to `ST_WIN`): a prefix arrives inside a window. The error is flagged and the window stays as it is.

The machine stays in `ST_IDLE` on reset, on a prefix with an all-zero mask, and on a flush.

Top module: `pps_seq`

## Requirements
- R1: After reset the block is idle. `win_active` is 0, `seq_err` is 0 and `cur_flags` is 0000.
- R2: Condition codes and their tests, with `cur_flags` packed as {N,Z,C,V}. The meaning of each code when it is not inverted:

  | Code | Test |
  |------|------|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C |
  | 3 | !C |
  | 4 | N |
  | 5 | !N |
  | 6 | V |
  | 7 | !V |
  | 8 | C&!Z |
  | 9 | !C\|Z |
  | 10 | N==V |
  | 11 | N!=V |
  | 12 | !Z&(N==V) |
  | 13 to 15 | always true |

- R3: Window length comes from the lowest set bit of `pfx_mask`. If that bit is at index i, the window has `NUM_SLOTS`-i slots. An all-zero mask opens no window.
- R4: Slot 0 uses the base condition. Slot k (k≥1) uses `pfx_mask[NUM_SLOTS-k]`, where 0 means the base condition and 1 means its inverse. The inverse of an always-true code is false.
- R5: While no window is open, `exec_en` equals `ins_valid`.
- R6: `cur_flags` takes `ins_flags` on a clock edge only when `ins_valid`, `ins_sets_flags` and `exec_en` are all high. Later slots are evaluated against the updated value.
- R7: A prefix that arrives while a window is open sets `seq_err` for exactly the next cycle. It is discarded, and the open window continues unchanged.
- R8: `exc_flush` closes any window on the next edge. The following instruction then executes regardless of condition.
- R9: The window advances one slot only on a cycle with `ins_valid`. Cycles with no issue hold it.
- R10: `exec_en` is never high while `ins_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_flush | input | 1 | Exception entry; closes the window |
| pfx_valid | input | 1 | Prefix instruction decoded this cycle |
| pfx_cond | input | 4 | Base condition code of the prefix |
| pfx_mask | input | NUM_SLOTS | Slot sense bits with trailing end marker |
| ins_valid | input | 1 | A non-prefix instruction issues this cycle (exclusive with pfx_valid) |
| ins_sets_flags | input | 1 | The issuing instruction writes the flags |
| ins_flags | input | 4 | New {N,Z,C,V} produced by that instruction |
| exec_en | output | 1 | Issuing instruction may change architectural state |
| win_active | output | 1 | A predicate window is open |
| seq_err | output | 1 | Prefix issued inside an open window (one-cycle pulse) |
| cur_flags | output | 4 | Current {N,Z,C,V} flag register |

## Verification
The bench builds the block with `NUM_SLOTS`=4, the default. This makes every window length from one to four slots reachable, including the longest window with a mixed then/else pattern. The 4-bit condition width exercises all thirteen tests and the always-true codes, in both senses. Flag writes within a window, illegal prefixes and flushes are placed at the first slot and in the middle of a window.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        C_ZSET  = 4'd0,
        C_ZCLR  = 4'd1,
        C_CSET  = 4'd2,
        C_CCLR  = 4'd3,
        C_NSET  = 4'd4,
        C_NCLR  = 4'd5,
        C_VSET  = 4'd6,
        C_VCLR  = 4'd7,
        C_UHI   = 4'd8,
        C_ULS   = 4'd9,
        C_SGE   = 4'd10,
        C_SLT   = 4'd11,
        C_SGT   = 4'd12,
        C_ALW   = 4'd13,
        C_ALW2  = 4'd14,
        C_ALW3  = 4'd15
    } cond_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WIN  = 1'b1
    } win_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/pps_cond_eval.sv
module pps_cond_eval
    import pps_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  flags_t            flg,
    output logic              hit
);

    logic sgn_eq;

    always_comb begin
        sgn_eq = (flg.n == flg.v);
        case (cond_e'(code))
            C_ZSET:  hit = flg.z;
            C_ZCLR:  hit = !flg.z;
            C_CSET:  hit = flg.c;
            C_CCLR:  hit = !flg.c;
            C_NSET:  hit = flg.n;
            C_NCLR:  hit = !flg.n;
            C_VSET:  hit = flg.v;
            C_VCLR:  hit = !flg.v;
            C_UHI:   hit = flg.c && !flg.z;
            C_ULS:   hit = !flg.c || flg.z;
            C_SGE:   hit = sgn_eq;
            C_SLT:   hit = !sgn_eq;
            C_SGT:   hit = !flg.z && sgn_eq;
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/pps_window_fsm.sv
module pps_window_fsm
    import pps_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 pfx_valid,
    input  logic [CODE_W-1:0]    pfx_cond,
    input  logic [NUM_SLOTS-1:0] pfx_mask,
    input  logic                 ins_valid,
    output logic                 active,
    output logic                 slot_inv,
    output logic [CODE_W-1:0]    base_cond,
    output logic                 seq_err
);

    localparam int SH_W = NUM_SLOTS + 1;

    win_state_e          state_q, state_d;
    logic [SH_W-1:0]     sh_q, sh_d, sh_step;
    logic [CODE_W-1:0]   cond_q, cond_d;
    logic                err_q, err_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cond_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cond_q  <= cond_d;
            err_q   <= err_d;
        end
    end

    // transitions: OPEN, STEP, LAST, FLUSH, ILLEGAL
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cond_d  = cond_q;
        err_d   = 1'b0;
        sh_step = {sh_q[SH_W-2:0], 1'b0};
        unique case (state_q)
            ST_IDLE: begin
                if (!flush && pfx_valid && (pfx_mask != '0)) begin
                    state_d = ST_WIN;
                    sh_d    = {1'b0, pfx_mask};
                    cond_d  = pfx_cond;
                end
            end
            ST_WIN: begin
                if (flush) begin
                    state_d = ST_IDLE;
                    sh_d    = '0;
                end else if (pfx_valid) begin
                    err_d = 1'b1;
                end else if (ins_valid) begin
                    if (sh_step[SH_W-2:0] == '0) begin
                        state_d = ST_IDLE;
                        sh_d    = '0;
                    end else begin
                        sh_d = sh_step;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        active    = (state_q == ST_WIN);
        slot_inv  = sh_q[SH_W-1];
        base_cond = cond_q;
        seq_err   = err_q;
    end

endmodule

// File: rtl/pps_flag_reg.sv
module pps_flag_reg
    import pps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  flags_t wr_val,
    output flags_t val
);

    always_ff @(posedge clk) begin
        if (!rst_n) val <= '0;
        else if (wr_en) val <= wr_val;
    end

endmodule

// File: rtl/pps_seq.sv
module pps_seq
    import pps_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_flush,
    input  logic                 pfx_valid,
    input  logic [3:0]           pfx_cond,
    input  logic [NUM_SLOTS-1:0] pfx_mask,
    input  logic                 ins_valid,
    input  logic                 ins_sets_flags,
    input  logic [3:0]           ins_flags,
    output logic                 exec_en,
    output logic                 win_active,
    output logic                 seq_err,
    output logic [3:0]           cur_flags
);

    logic              slot_inv;
    logic [CODE_W-1:0] base_cond;
    logic              cond_hit;
    flags_t            flg_q;

    pps_window_fsm #(.NUM_SLOTS(NUM_SLOTS)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (exc_flush),
        .pfx_valid (pfx_valid),
        .pfx_cond  (pfx_cond),
        .pfx_mask  (pfx_mask),
        .ins_valid (ins_valid),
        .active    (win_active),
        .slot_inv  (slot_inv),
        .base_cond (base_cond),
        .seq_err   (seq_err)
    );

    pps_cond_eval eval_i (
        .code (base_cond),
        .flg  (flg_q),
        .hit  (cond_hit)
    );

    always_comb begin
        exec_en = ins_valid && (win_active ? (cond_hit ^ slot_inv) : 1'b1);
    end

    pps_flag_reg flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (exec_en && ins_sets_flags),
        .wr_val (flags_t'(ins_flags)),
        .val    (flg_q)
    );

    assign cur_flags = flg_q;

endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exc_flush,
    input logic       pfx_valid,
    input logic       ins_valid,
    input logic       exec_en,
    input logic       win_active,
    input logic       seq_err,
    input logic [3:0] cur_flags
);

    a_r10_no_enable_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> !exec_en);

    a_r5_idle_executes: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_active && ins_valid) |-> exec_en);

    a_r8_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flush |=> !win_active);

    a_r7_illegal_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && win_active && !exc_flush) |=> (seq_err && win_active));

    a_r6_squashed_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !exec_en) |=> $stable(cur_flags));

    a_r9_hold_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !pfx_valid && !exc_flush) |=> $stable(win_active));

endmodule

bind pps_seq pps_seq_chk chk_i (.*);

// File: tb/pps_seq_tb_top.sv
module pps_seq_tb_top;

    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_flush = 1'b0;
    logic          pfx_valid = 1'b0;
    logic [3:0]    pfx_cond = '0;
    logic [NS-1:0] pfx_mask = '0;
    logic          ins_valid = 1'b0;
    logic          ins_sets_flags = 1'b0;
    logic [3:0]    ins_flags = '0;
    logic          exec_en, win_active, seq_err;
    logic [3:0]    cur_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pps_seq #(.NUM_SLOTS(NS)) dut_i (.*);

    // {flags NZCV, cond, expected non-inverted result}
    localparam logic [8:0] VEC [18] = '{
        {4'b0100, 4'd0,  1'b1}, {4'b0000, 4'd0,  1'b0},
        {4'b0000, 4'd1,  1'b1}, {4'b0010, 4'd2,  1'b1},
        {4'b0010, 4'd3,  1'b0}, {4'b1000, 4'd4,  1'b1},
        {4'b1000, 4'd5,  1'b0}, {4'b0001, 4'd6,  1'b1},
        {4'b0000, 4'd7,  1'b1}, {4'b0010, 4'd8,  1'b1},
        {4'b0110, 4'd8,  1'b0}, {4'b0110, 4'd9,  1'b1},
        {4'b1001, 4'd10, 1'b1}, {4'b1000, 4'd11, 1'b1},
        {4'b0101, 4'd12, 1'b0}, {4'b1001, 4'd12, 1'b1},
        {4'b0000, 4'd13, 1'b1}, {4'b0100, 4'd15, 1'b1}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one instruction; checks exec_en before the edge
    task automatic issue(input logic sets, input logic [3:0] nf, input logic exp_en, input string tag);
        @(negedge clk);
        ins_valid = 1'b1; ins_sets_flags = sets; ins_flags = nf;
        #3 chk(tag, {3'b0, exec_en}, {3'b0, exp_en});
        @(posedge clk); #1;
        ins_valid = 1'b0; ins_sets_flags = 1'b0;
    endtask

    task automatic prefix(input logic [3:0] c, input logic [NS-1:0] m);
        @(negedge clk);
        pfx_valid = 1'b1; pfx_cond = c; pfx_mask = m;
        @(posedge clk); #1;
        pfx_valid = 1'b0;
    endtask

    task automatic set_flags(input logic [3:0] f);
        issue(1'b1, f, 1'b1, "R5 idle flag write");
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R10 no issue no enable
        chk("R1 win_active", {3'b0, win_active}, 4'd0);
        chk("R1 seq_err", {3'b0, seq_err}, 4'd0);
        chk("R1 flags", cur_flags, 4'd0);
        @(negedge clk); #3 chk("R10 idle no issue", {3'b0, exec_en}, 4'd0);
        @(posedge clk); #1;
        issue(1'b0, 4'd0, 1'b1, "R5 idle executes");

        // R2 / R4 table: slot0 base sense, slot1 inverted
        for (int i = 0; i < 18; i++) begin
            set_flags(VEC[i][8:5]);
            chk("R6 flag write idle", cur_flags, VEC[i][8:5]);
            prefix(VEC[i][4:1], 4'b1100);
            issue(1'b0, 4'd0, VEC[i][0], $sformatf("R2 cond %0d slot0", VEC[i][4:1]));
            issue(1'b0, 4'd0, !VEC[i][0], $sformatf("R4 cond %0d slot1 inverted", VEC[i][4:1]));
            chk("R3 two-slot window closed", {3'b0, win_active}, 4'd0);
        end

        // R3 longest window; R9 idle cycles hold
        prefix(4'd13, 4'b0001);
        for (int s = 0; s < 4; s++) begin
            chk("R3 window open", {3'b0, win_active}, 4'd1);
            idle_cycle();
            chk("R9 held by idle cycle", {3'b0, win_active}, 4'd1);
            issue(1'b0, 4'd0, 1'b1, "R3 always slot");
        end
        chk("R3 four-slot window closed", {3'b0, win_active}, 4'd0);

        // R4 mixed pattern, three slots
        prefix(4'd13, 4'b1010);
        issue(1'b0, 4'd0, 1'b1, "R4 slot0 then");
        issue(1'b0, 4'd0, 1'b0, "R4 slot1 else of always");
        issue(1'b0, 4'd0, 1'b1, "R4 slot2 then");
        chk("R3 three-slot closed", {3'b0, win_active}, 4'd0);

        // R3 zero mask opens nothing
        set_flags(4'b0000);
        prefix(4'd0, 4'b0000);
        chk("R3 zero mask no window", {3'b0, win_active}, 4'd0);
        issue(1'b0, 4'd0, 1'b1, "R3 zero mask unconditional");

        // R6 flag changes inside window
        set_flags(4'b0100);
        prefix(4'd0, 4'b0010);
        issue(1'b1, 4'b0000, 1'b1, "R6 slot0 clears Z");
        chk("R6 flags updated", cur_flags, 4'b0000);
        issue(1'b1, 4'b0100, 1'b0, "R6 slot1 sees new flags");
        chk("R6 squashed write ignored", cur_flags, 4'b0000);
        issue(1'b0, 4'd0, 1'b0, "R6 slot2 still false");
        chk("R6 window closed", {3'b0, win_active}, 4'd0);

        // R7 illegal prefix
        set_flags(4'b0100);
        prefix(4'd13, 4'b0100);
        issue(1'b0, 4'd0, 1'b1, "R7 slot0");
        prefix(4'd1, 4'b1000);
        chk("R7 seq_err raised", {3'b0, seq_err}, 4'd1);
        chk("R7 window kept", {3'b0, win_active}, 4'd1);
        issue(1'b0, 4'd0, 1'b1, "R7 old condition still used");
        chk("R7 seq_err one cycle", {3'b0, seq_err}, 4'd0);
        chk("R7 original length", {3'b0, win_active}, 4'd0);

        // R8 flush mid window
        set_flags(4'b0000);
        prefix(4'd0, 4'b0001);
        issue(1'b0, 4'd0, 1'b0, "R8 slot0 false");
        @(negedge clk); exc_flush = 1'b1;
        @(posedge clk); #1 exc_flush = 1'b0;
        chk("R8 flush closes", {3'b0, win_active}, 4'd0);
        issue(1'b0, 4'd0, 1'b1, "R8 unconditional after flush");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule